// File: doc/BRIEF.md
# Equivalent-Time Waveform Capture Sequencer

This block is the digital controller for an on-chip voltage monitor built around a sampling latch comparator. It drives two codes to external generators. The reference code sets the comparison level. The strobe-delay code sets where in the monitored circuit's periodic activity the comparator fires. The monitored circuit repeats the same activity over and over, and each repetition is announced on a trigger input. For one strobe delay, the block collects many comparator decisions at a fixed reference code and counts how many of them were 1. It uses that fraction to decide which way to move the reference code.

The level at each delay point is resolved by a binary search over the reference code, most significant bit first. A comparator 1 means the reference sits above the sampled voltage. When more than half of a trial's samples are 1, the bit under test is cleared; otherwise it is kept. Once the last bit is decided, the block offers the pair (point index, final code) on a valid/ready result stream. It then advances the strobe delay by a fixed step and starts again from the top bit. The sequence of results, in order, is the captured waveform in equivalent time.

Software-style settings are plain inputs and are latched when a capture starts: the number of points, the first delay, the delay step, the repetitions per trial and the settle time. An abort input drops any capture in progress.

Top module: `etcap_seq`

## Requirements
- R1: After reset, `busy`, `done` and `res_valid` are 0 and `ref_code` is 0.
- R2: Each point runs one trial per code bit, starting with the top bit. Every trial drives a code that has its bit under test set, with the bits already decided kept. A bit is cleared when the count of 1 samples in its trial, doubled, exceeds the repetition count; otherwise it is kept. With a comparator that outputs 1 exactly when `ref_code` is greater than a fixed level L, the result code equals L.
- R3: The decision threshold is strict. With exactly half of the samples at 1, the bit is kept, so every bit kept gives the all-ones code. With more than half at 1 in every trial, the result is 0.
- R4: A trial takes `cfg_reps` comparator samples (`cfg_reps` must be nonzero), each taken after its own trigger. Decisions follow the majority of those samples, so a minority of wrong comparator outputs in every trial does not change the result.
- R5: After the clock edge that sees `trig` high in the waiting state, the comparator is sampled at the edge `cfg_settle + 1` cycles later.
- R6: During point i (counted from 0), `strobe_dly` equals `cfg_dly0 + i * cfg_step`, taken modulo 2^DLY_W. It holds steady for all trials of that point and while its result is offered, and `res_index` equals i.
- R7: A result stays valid, with `res_code` and `res_index` unchanged, until `res_ready` accepts it. Exactly `cfg_points` results are produced, in index order. After the last result is accepted, `busy` falls and `done` rises. `done` clears on the next accepted start.
- R8: A start with `cfg_points` equal to 0 sets `done` at the next edge, keeps `busy` low and produces no result.
- R9: While a capture is in progress, `start` is ignored. The settings are latched at the accepted start, so later changes to the configuration inputs do not alter the running capture.
- R10: `abort` returns the block to idle at the next edge, with `busy`, `res_valid` and `done` low. It also clears the sample counts, so the next capture's first trial is not affected by samples taken before the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a capture (accepted only when idle) |
| abort | input | 1 | Abandon capture and return to idle |
| cfg_points | input | PT_W | Number of delay points to capture |
| cfg_dly0 | input | DLY_W | Strobe delay of the first point |
| cfg_step | input | DLY_W | Strobe delay increment between points |
| cfg_reps | input | REP_W | Comparator samples per trial (nonzero) |
| cfg_settle | input | SET_W | Extra clocks between trigger and sample |
| trig | input | 1 | One-cycle marker of each repetition of the monitored activity |
| cmp_bit | input | 1 | Comparator decision, 1 when reference is above the sampled voltage |
| ref_code | output | CODE_W | Reference level code to the voltage generator |
| strobe_dly | output | DLY_W | Strobe delay code to the timing generator |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Last capture completed |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result accepted by consumer |
| res_index | output | PT_W | Delay point index of the result |
| res_code | output | CODE_W | Resolved reference code of the result |

## Verification
An ideal comparator tied to a level that depends on the strobe delay checks that the search lands exactly on that level at every point. It also shows that the delay sweep, including wrap-around, presents the right code for each index. Fixed per-trial patterns of 1 counts separate a strict threshold from a non-strict one, since exactly half ones must give all-ones and more than half must give zero. A minority of wrong samples in every trial checks the majority behaviour. A comparator that is 1 only in the single cycle where the settle rule says to sample shows whether sampling happens at the right cycle. Back-pressure on the result stream, a second start in mid-run with altered settings, an abort taken after some samples were already counted, and a zero-point start cover the control corners.

// File: rtl/etcap_pkg.sv
`timescale 1ns/1ps
package etcap_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_DECIDE = 3'd3,
        ST_EMIT   = 3'd4
    } etcap_st_e;

    // Strict majority: twice the ones count must exceed the repetitions
    function automatic logic more_than_half(input logic [31:0] ones,
                                            input logic [31:0] reps);
        return (33'(ones) << 1) > 33'(reps);
    endfunction

endpackage

// File: rtl/etcap_accum.sv
`timescale 1ns/1ps
module etcap_accum
    import etcap_pkg::*;
#(
    parameter int REP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp,
    input  logic             bit_in,
    input  logic [REP_W-1:0] reps,
    output logic             trial_end,
    output logic             over_half
);

    logic [REP_W-1:0] rep_cnt;
    logic [REP_W-1:0] one_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rep_cnt <= '0;
            one_cnt <= '0;
        end else if (smp) begin
            rep_cnt <= rep_cnt + 1'b1;
            one_cnt <= one_cnt + REP_W'(bit_in);
        end
    end

    assign trial_end = smp && ((rep_cnt + 1'b1) == reps);
    assign over_half = more_than_half(32'(one_cnt), 32'(reps));

    // R4
    ones_bound_chk: assert property (@(posedge clk) disable iff (rst)
        one_cnt <= rep_cnt);

endmodule

// File: rtl/etcap_srch.sv
`timescale 1ns/1ps
module etcap_srch #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              park,
    input  logic              decide,
    input  logic              lower,
    output logic [CODE_W-1:0] code,
    output logic              last
);

    localparam logic [CODE_W-1:0] TOP_BIT = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] mask;
    logic [CODE_W-1:0] kept;

    assign kept = lower ? (code & ~mask) : code;
    assign last = mask[0];

    always_ff @(posedge clk) begin
        if (rst || park) begin
            code <= '0;
            mask <= '0;
        end else if (init) begin
            code <= TOP_BIT;
            mask <= TOP_BIT;
        end else if (decide) begin
            if (mask[0]) begin
                code <= kept;
                mask <= '0;
            end else begin
                code <= kept | (mask >> 1);
                mask <= mask >> 1;
            end
        end
    end

    // R2
    code_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (decide && lower && !park && !init) |=> (code < $past(code)));

    // R2
    code_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (decide && !lower && !park && !init) |=> (code >= $past(code)));

endmodule

// File: rtl/etcap_tstep.sv
`timescale 1ns/1ps
module etcap_tstep #(
    parameter int PT_W  = 8,
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [DLY_W-1:0] dly0,
    input  logic [DLY_W-1:0] step,
    output logic [PT_W-1:0]  idx,
    output logic [DLY_W-1:0] dly
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            dly <= '0;
        end else if (load) begin
            idx <= '0;
            dly <= dly0;
        end else if (adv) begin
            idx <= idx + 1'b1;
            dly <= dly + step;
        end
    end

endmodule

// File: rtl/etcap_seq.sv
`timescale 1ns/1ps
module etcap_seq
    import etcap_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int REP_W  = 10,
    parameter int PT_W   = 8,
    parameter int DLY_W  = 10,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [PT_W-1:0]   cfg_points,
    input  logic [DLY_W-1:0]  cfg_dly0,
    input  logic [DLY_W-1:0]  cfg_step,
    input  logic [REP_W-1:0]  cfg_reps,
    input  logic [SET_W-1:0]  cfg_settle,
    input  logic              trig,
    input  logic              cmp_bit,
    output logic [CODE_W-1:0] ref_code,
    output logic [DLY_W-1:0]  strobe_dly,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [PT_W-1:0]   res_index,
    output logic [CODE_W-1:0] res_code
);

    etcap_st_e        st;
    logic [PT_W-1:0]  pts_q;
    logic [REP_W-1:0] reps_q;
    logic [SET_W-1:0] settle_q;
    logic [SET_W-1:0] set_cnt;
    logic [DLY_W-1:0] step_q;

    logic go, empty_go, smp, emit_fire, last_pt, finish;
    logic trial_end, over_half, last_bit;
    logic acc_clr, srch_init, srch_park, srch_dec, pt_adv;
    logic [PT_W-1:0]   idx;
    logic [CODE_W-1:0] code;

    assign go        = (st == ST_IDLE) && start && !abort && (cfg_points != '0);
    assign empty_go  = (st == ST_IDLE) && start && !abort && (cfg_points == '0);
    assign smp       = (st == ST_SETTLE) && (set_cnt == '0) && !abort;
    assign emit_fire = (st == ST_EMIT) && res_ready && !abort;
    assign last_pt   = (idx == pts_q - 1'b1);
    assign finish    = emit_fire && last_pt;

    assign acc_clr   = abort || go || (st == ST_DECIDE);
    assign srch_init = go || (emit_fire && !last_pt);
    assign srch_park = abort || finish;
    assign srch_dec  = (st == ST_DECIDE) && !abort;
    assign pt_adv    = emit_fire && !last_pt;

    etcap_accum #(.REP_W(REP_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clr       (acc_clr),
        .smp       (smp),
        .bit_in    (cmp_bit),
        .reps      (reps_q),
        .trial_end (trial_end),
        .over_half (over_half)
    );

    etcap_srch #(.CODE_W(CODE_W)) u_srch (
        .clk    (clk),
        .rst    (rst),
        .init   (srch_init),
        .park   (srch_park),
        .decide (srch_dec),
        .lower  (over_half),
        .code   (code),
        .last   (last_bit)
    );

    etcap_tstep #(.PT_W(PT_W), .DLY_W(DLY_W)) u_tstep (
        .clk  (clk),
        .rst  (rst),
        .load (go),
        .adv  (pt_adv),
        .dly0 (cfg_dly0),
        .step (step_q),
        .idx  (idx),
        .dly  (strobe_dly)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            done     <= 1'b0;
            pts_q    <= '0;
            reps_q   <= '0;
            settle_q <= '0;
            step_q   <= '0;
            set_cnt  <= '0;
        end else if (abort) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st       <= ST_WAIT;
                        done     <= 1'b0;
                        pts_q    <= cfg_points;
                        reps_q   <= cfg_reps;
                        settle_q <= cfg_settle;
                        step_q   <= cfg_step;
                    end else if (empty_go) begin
                        done <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (trig) begin
                        st      <= ST_SETTLE;
                        set_cnt <= settle_q;
                    end
                end
                ST_SETTLE: begin
                    if (set_cnt != '0) begin
                        set_cnt <= set_cnt - 1'b1;
                    end else begin
                        st <= trial_end ? ST_DECIDE : ST_WAIT;
                    end
                end
                ST_DECIDE: begin
                    st <= last_bit ? ST_EMIT : ST_WAIT;
                end
                ST_EMIT: begin
                    if (res_ready) begin
                        if (last_pt) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign res_valid = (st == ST_EMIT);
    assign res_index = idx;
    assign res_code  = code;
    assign ref_code  = code;

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready && !abort) |=>
            (res_valid && $stable(res_code) && $stable(res_index)));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !res_valid && !done));

    // R6
    dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !res_valid) |=> (strobe_dly == $past(strobe_dly)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !res_valid && !abort) |=> busy);

endmodule

// File: tb/sim_etcap_seq.sv
`timescale 1ns/1ps
module sim_etcap_seq;

    localparam int CODE_W = 8;
    localparam int REP_W  = 10;
    localparam int PT_W   = 8;
    localparam int DLY_W  = 10;
    localparam int SET_W  = 4;
    localparam int TPER   = 6;
    localparam int NVEC   = 7;

    // columns: points, first delay, step, reps, settle, comparator mode, k, back-pressure
    localparam int VEC [NVEC][8] = '{
        '{4,    0,  1, 1, 0, 0, 0, 0},
        '{5,  100, 37, 3, 2, 0, 0, 1},
        '{3, 1000, 20, 5, 1, 0, 0, 0},
        '{2,   10,  1, 4, 0, 2, 2, 0},
        '{2,   10,  1, 4, 0, 2, 3, 0},
        '{2,   50,  3, 7, 2, 3, 3, 0},
        '{2,    7,  2, 2, 3, 1, 0, 0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, start, abort, trig, cmp_bit, res_ready;
    logic [PT_W-1:0]   cfg_points;
    logic [DLY_W-1:0]  cfg_dly0, cfg_step;
    logic [REP_W-1:0]  cfg_reps;
    logic [SET_W-1:0]  cfg_settle;
    logic [CODE_W-1:0] ref_code, res_code;
    logic [DLY_W-1:0]  strobe_dly;
    logic [PT_W-1:0]   res_index;
    logic busy, done, res_valid;

    int checks = 0;
    int fails  = 0;
    int gen_on = 0;
    int mode   = 0;
    int kpar   = 0;
    int cur_reps = 1;
    int cur_settle = 0;
    int gcnt, tcount, tidx, since;
    int cyc = 0;

    etcap_seq #(
        .CODE_W(CODE_W), .REP_W(REP_W), .PT_W(PT_W), .DLY_W(DLY_W), .SET_W(SET_W)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cfg_points(cfg_points), .cfg_dly0(cfg_dly0), .cfg_step(cfg_step),
        .cfg_reps(cfg_reps), .cfg_settle(cfg_settle),
        .trig(trig), .cmp_bit(cmp_bit),
        .ref_code(ref_code), .strobe_dly(strobe_dly),
        .busy(busy), .done(done),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_index(res_index), .res_code(res_code)
    );

    function automatic int vfun(input int d);
        return (d * 29 + 77) % 256;
    endfunction

    function automatic int exp_code(input int md, input int k, input int reps, input int d);
        if (md == 0 || md == 3) return vfun(d);
        if (md == 1) return 0;
        return (2 * k > reps) ? 0 : 255;
    endfunction

    function automatic string mode_req(input int md);
        if (md == 1) return "R5";
        if (md == 2) return "R3";
        if (md == 3) return "R4";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Trigger and comparator model, updated away from the active edge
    initial begin
        trig = 1'b0; cmp_bit = 1'b0;
        gcnt = 0; tcount = 0; tidx = -1; since = 100;
        forever begin
            @(negedge clk);
            cyc++;
            if (gen_on != 0) begin
                gcnt++;
                if (gcnt % TPER == 0) begin
                    trig = 1'b1; since = 0; tcount++; tidx = tcount - 1;
                end else begin
                    trig = 1'b0; since++;
                end
            end else begin
                trig = 1'b0; gcnt = 0; tcount = 0; tidx = -1; since = 100;
            end
            case (mode)
                1: cmp_bit = (since == cur_settle + 1);
                2: cmp_bit = ((tidx % cur_reps) < kpar);
                3: cmp_bit = (int'(ref_code) > vfun(int'(strobe_dly))) ^ ((tidx % cur_reps) < kpar);
                default: cmp_bit = (int'(ref_code) > vfun(int'(strobe_dly)));
            endcase
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic capture(input int pts, input int d0, input int stp, input int reps,
                           input int setl, input int md, input int k, input bit bp,
                           input int poke);
        int n = 0;
        int cycles = 0;
        @(negedge clk);
        cfg_points = PT_W'(pts); cfg_dly0 = DLY_W'(d0); cfg_step = DLY_W'(stp);
        cfg_reps = REP_W'(reps); cfg_settle = SET_W'(setl);
        mode = md; kpar = k; cur_reps = reps; cur_settle = setl;
        start = 1'b1; gen_on = 1; res_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: done cleared by the accepted start
        chk(done == 1'b0 && busy == 1'b1, "R7 start", int'(done), 0);
        while (cycles < 20000) begin
            cycles++;
            if (poke > 0 && cycles == poke) begin
                start = 1'b1; cfg_points = PT_W'(pts + 3);
                cfg_dly0 = DLY_W'(d0 + 5); cfg_reps = REP_W'(1); cfg_step = DLY_W'(stp + 1);
            end else if (poke > 0 && cycles == poke + 1) begin
                start = 1'b0;
            end
            res_ready = bp ? (cycles % 3 != 0) : 1'b1;
            if (res_valid && res_ready) begin
                int ed = (d0 + n * stp) % (1 << DLY_W);
                int ec = exp_code(md, k, reps, ed);
                chk(int'(res_code) == ec, poke > 0 ? "R9 code" : mode_req(md), int'(res_code), ec);
                chk(int'(res_index) == n, "R6 index", int'(res_index), n);
                chk(int'(strobe_dly) == ed, "R6 delay", int'(strobe_dly), ed);
                n++;
            end
            if (done && !busy) break;
            @(negedge clk);
        end
        gen_on = 0; res_ready = 1'b1;
        chk(n == pts, poke > 0 ? "R9 count" : "R7 count", n, pts);
        chk(done == 1'b1 && busy == 1'b0, "R7 done", int'(done), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; abort = 1'b0; res_ready = 1'b1;
        cfg_points = '0; cfg_dly0 = '0; cfg_step = '0; cfg_reps = REP_W'(1); cfg_settle = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R1 flags", int'(busy), 0);
        chk(ref_code == '0, "R1 ref_code", int'(ref_code), 0);

        for (int v = 0; v < NVEC; v++) begin
            capture(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                    VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7] != 0, 0);
        end

        // R9: second start with altered settings in mid-run
        capture(2, 20, 4, 2, 0, 0, 0, 1'b0, 25);

        // R10: abort after samples were counted
        @(negedge clk);
        cfg_points = PT_W'(3); cfg_dly0 = '0; cfg_step = DLY_W'(1);
        cfg_reps = REP_W'(8); cfg_settle = '0;
        mode = 0; cur_reps = 8; cur_settle = 0;
        start = 1'b1; gen_on = 1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0; gen_on = 0;
        chk(busy == 1'b0 && res_valid == 1'b0 && done == 1'b0, "R10 idle", int'(busy), 0);
        chk(ref_code == '0, "R10 ref_code", int'(ref_code), 0);
        repeat (2) @(negedge clk);

        // R8: zero points
        cfg_points = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R8 done", int'(done), 1);
        chk(res_valid == 1'b0, "R8 no result", int'(res_valid), 0);
        repeat (2) @(negedge clk);

        // R10: capture after abort must not see stale counts
        capture(2, 2, 1, 8, 0, 0, 0, 1'b0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule